// File: doc/BRIEF.md
# Slow-Access Wait-State Controller

This block lets a processor that runs from a fast clock reach memory and I/O on a slower system bus. An outside decoder flags addresses that belong to the slow bus. The controller then pulls the processor's ready line low and holds the processor. It waits for the bus-clock slot in which a bus access may begin, keeps the access open until the closing slot, and then releases the processor. The bus clock is a divided copy of the fast clock, and two strobes mark the opening slot (Q3) and the closing slot (Q7) inside the high half of each bus period.

Everything is registered on the rising edge of the fast clock. The request comes from a rising edge of the registered decode, so it is a one-cycle pulse. The controller ignores requests until the processor has fetched its reset vector. This keeps a half-built cycle from running while reset holds the processor outside the ready handshake. A delayed copy of the slow-cycle flag keeps the bus selects alive until the bus clock falls. The bus data transceiver is enabled only inside a slow cycle and only while the bank-latch strobe is low.

Top module: `slow_wait_ctrl`

## Requirements
- R1: While `rst_n` is low and on the first clock after it rises, `cpu_rdy` is 1 and `slow_active`, `slow_hold` and `xcvr_en` are 0.
- R2: Until `vector_fetch` has been seen high at a rising edge with `rst_n` high, a `slow_hit` produces no stall: `cpu_rdy` stays 1 and `slow_active` stays 0.
- R3: A request is formed only by a 0-to-1 change of the registered `slow_hit`. A decode held high for many cycles after an access ends starts no second access, and `cpu_rdy` stays 1.
- R4: With the default of one settle stage, when `slow_hit` rises before edge E1, `cpu_rdy` goes low after edge E2. `slow_active` is not set at that edge.
- R5: `slow_active` is set only at an edge that samples `q3_strobe` high while `cpu_rdy` is already low. A Q3 sampled at the same edge that takes `cpu_rdy` low does not start the cycle.
- R6: A request that misses Q3 within a bus-high phase waits for the Q3 of the next bus period. `slow_active` stays 0 until then.
- R7: At an edge that samples `q7_strobe` and `bus_ready` both high while `slow_active` is 1, `slow_active` clears and `cpu_rdy` returns to 1 at that same edge.
- R8: If `bus_ready` is low when Q7 is sampled, the slow cycle continues, and it ends at the next Q7 sampled with `bus_ready` high.
- R9: `slow_hold` rises one edge after `slow_active`. It stays 1 after `slow_active` clears until an edge samples `bus_clk` low, and it clears at that edge.
- R10: `xcvr_en` is 1 exactly when `slow_active` is 1 and `bank_latch` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cpu_clk | input | 1 | Fast processor clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset, tied to the processor reset |
| bus_clk | input | 1 | Slow bus clock level (high = bus access phase) |
| q3_strobe | input | 1 | One-fast-cycle strobe marking the slot that opens a bus access |
| q7_strobe | input | 1 | One-fast-cycle strobe marking the slot that closes a bus access |
| slow_hit | input | 1 | Address decode: current access targets the slow bus |
| bus_ready | input | 1 | Ready line from the slow bus; low stretches the access |
| vector_fetch | input | 1 | High while the processor reads its reset vector |
| bank_latch | input | 1 | Bank-address latch strobe; high cuts the data transceiver |
| cpu_rdy | output | 1 | Ready to the processor; low holds it |
| slow_active | output | 1 | Slow bus cycle in progress; qualifies the bus selects |
| slow_hold | output | 1 | Delayed slow-cycle flag, held until the bus clock falls |
| xcvr_en | output | 1 | Enable for the bus data transceiver |

## Verification
Two collisions can land in the same clock. The new request pulse can meet the Q3 strobe, and the Q7 strobe can meet a low bus ready. The bench places the decode edge so that the stall begins at the very edge that samples Q3. It checks that the cycle opens only one bus period later. It also drops bus ready just before a Q7 and checks that the slow cycle lasts a full extra period and ends at the following Q7. In every case the bench works out the expected opening edge from the bus phase at which the decode rose.

// File: rtl/wsc_pkg.sv
package wsc_pkg;

  typedef enum logic [1:0] {
    WS_IDLE  = 2'd0,
    WS_STALL = 2'd1,
    WS_BUS   = 2'd2
  } ws_state_t;

  // Next state of the wait-state sequencer.
  function automatic ws_state_t ws_next(ws_state_t cur, logic fire,
                                        logic open_slot, logic close_slot,
                                        logic bus_ok);
    ws_state_t nxt;
    nxt = cur;
    case (cur)
      WS_IDLE:  if (fire)                  nxt = WS_STALL;
      WS_STALL: if (open_slot)             nxt = WS_BUS;
      WS_BUS:   if (close_slot && bus_ok)  nxt = WS_IDLE;
      default:                             nxt = WS_IDLE;
    endcase
    return nxt;
  endfunction

  // Delayed select flag: follows the cycle flag, held while the bus clock is high.
  function automatic logic hold_next(logic active, logic held, logic bus_high);
    return active | (held & bus_high);
  endfunction

endpackage

// File: rtl/wsc_arm.sv
module wsc_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic vector_fetch,
  output logic armed
);
  always_ff @(posedge clk) begin
    if (!rst_n)            armed <= 1'b0;
    else if (vector_fetch) armed <= 1'b1;
  end
endmodule

// File: rtl/wsc_req.sv
module wsc_req #(
  parameter int SETTLE_STAGES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slow_hit,
  input  logic armed,
  output logic req_fire
);
  localparam int LAST = SETTLE_STAGES - 1;

  logic [SETTLE_STAGES-1:0] settle_q;
  logic                     prev_q;

  generate
    if (SETTLE_STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n) settle_q <= '0;
        else        settle_q <= slow_hit;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (!rst_n) settle_q <= '0;
        else        settle_q <= {settle_q[SETTLE_STAGES-2:0], slow_hit};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= settle_q[LAST];
  end

  assign req_fire = armed & settle_q[LAST] & ~prev_q;
endmodule

// File: rtl/wsc_fsm.sv
module wsc_fsm
  import wsc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_fire,
  input  logic q3_strobe,
  input  logic q7_strobe,
  input  logic bus_ready,
  output logic stalled,
  output logic in_bus
);
  ws_state_t state;

  always_ff @(posedge clk) begin
    if (!rst_n) state <= WS_IDLE;
    else        state <= ws_next(state, req_fire, q3_strobe, q7_strobe, bus_ready);
  end

  assign stalled = (state != WS_IDLE);
  assign in_bus  = (state == WS_BUS);
endmodule

// File: rtl/slow_wait_ctrl.sv
module slow_wait_ctrl
  import wsc_pkg::*;
#(
  parameter int SETTLE_STAGES = 1
) (
  input  logic cpu_clk,
  input  logic rst_n,
  input  logic bus_clk,
  input  logic q3_strobe,
  input  logic q7_strobe,
  input  logic slow_hit,
  input  logic bus_ready,
  input  logic vector_fetch,
  input  logic bank_latch,
  output logic cpu_rdy,
  output logic slow_active,
  output logic slow_hold,
  output logic xcvr_en
);
  logic armed;
  logic req_fire;
  logic stalled;
  logic in_bus;

  wsc_arm u_arm (
    .clk          (cpu_clk),
    .rst_n        (rst_n),
    .vector_fetch (vector_fetch),
    .armed        (armed)
  );

  wsc_req #(.SETTLE_STAGES(SETTLE_STAGES)) u_req (
    .clk      (cpu_clk),
    .rst_n    (rst_n),
    .slow_hit (slow_hit),
    .armed    (armed),
    .req_fire (req_fire)
  );

  wsc_fsm u_fsm (
    .clk       (cpu_clk),
    .rst_n     (rst_n),
    .req_fire  (req_fire),
    .q3_strobe (q3_strobe),
    .q7_strobe (q7_strobe),
    .bus_ready (bus_ready),
    .stalled   (stalled),
    .in_bus    (in_bus)
  );

  always_ff @(posedge cpu_clk) begin
    if (!rst_n) slow_hold <= 1'b0;
    else        slow_hold <= hold_next(in_bus, slow_hold, bus_clk);
  end

  assign cpu_rdy     = ~stalled;
  assign slow_active = in_bus;
  assign xcvr_en     = in_bus & ~bank_latch;

  // R2: nothing stalls before the reset-vector fetch has armed the block
  assert_inert_unarmed_R2: assert property (@(posedge cpu_clk) disable iff (!rst_n)
    !armed |-> cpu_rdy);

  // R4: the stall begins only in answer to a request pulse
  assert_stall_from_request_R4: assert property (@(posedge cpu_clk) disable iff (!rst_n)
    $fell(cpu_rdy) |-> $past(req_fire) && !slow_active);

  // R5: the bus cycle opens only on a Q3 sampled while already stalled
  assert_open_on_q3_R5: assert property (@(posedge cpu_clk) disable iff (!rst_n)
    $rose(slow_active) |-> $past(q3_strobe) && !$past(cpu_rdy));

  // R7: the bus cycle closes only on Q7 with the bus ready, releasing the CPU
  assert_close_on_q7_R7: assert property (@(posedge cpu_clk) disable iff (!rst_n)
    $fell(slow_active) |-> $past(q7_strobe) && $past(bus_ready) && cpu_rdy);

  // R8: a low bus ready at Q7 keeps the cycle open
  assert_stretch_R8: assert property (@(posedge cpu_clk) disable iff (!rst_n)
    (slow_active && q7_strobe && !bus_ready) |=> slow_active);

  // R9: the delayed flag covers the whole cycle
  assert_hold_covers_R9: assert property (@(posedge cpu_clk) disable iff (!rst_n)
    $past(slow_active) |-> slow_hold);

  // R10: the transceiver never drives outside a slow cycle
  assert_xcvr_gated_R10: assert property (@(posedge cpu_clk) disable iff (!rst_n)
    xcvr_en |-> !cpu_rdy);
endmodule

// File: tb/slow_wait_ctrl_test.sv
module slow_wait_ctrl_test;
  logic cpu_clk = 1'b0;
  logic rst_n = 1'b0;
  logic slow_hit = 1'b0;
  logic bus_ready = 1'b1;
  logic vector_fetch = 1'b0;
  logic bank_latch = 1'b0;
  logic [2:0] ph = 3'd0;
  logic bus_clk, q3_strobe, q7_strobe;
  logic cpu_rdy, slow_active, slow_hold, xcvr_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 cpu_clk = ~cpu_clk;

  // Bus timing generator: eight fast cycles per bus period.
  always_ff @(posedge cpu_clk) ph <= ph + 3'd1;
  assign bus_clk   = ph[2];
  assign q3_strobe = (ph == 3'd5);
  assign q7_strobe = (ph == 3'd7);

  slow_wait_ctrl uut (
    .cpu_clk(cpu_clk), .rst_n(rst_n), .bus_clk(bus_clk),
    .q3_strobe(q3_strobe), .q7_strobe(q7_strobe), .slow_hit(slow_hit),
    .bus_ready(bus_ready), .vector_fetch(vector_fetch), .bank_latch(bank_latch),
    .cpu_rdy(cpu_rdy), .slow_active(slow_active), .slow_hold(slow_hold),
    .xcvr_en(xcvr_en)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge cpu_clk);
  endtask

  // Negedge index (after raising the decode) at which the cycle is first visible.
  function automatic int open_index(input int start_ph);
    for (int k = 3; k < 20; k++)
      if (((start_ph + k - 1) % 8) == 5) return k;
    return -1;
  endfunction

  task automatic wait_phase(input int p);
    while (int'(ph) != p) tick();
  endtask

  task automatic test_reset();
    tick();
    check("R1 rdy in reset", cpu_rdy, 1);
    check("R1 active in reset", slow_active, 0);
    check("R1 hold in reset", slow_hold, 0);
    check("R1 xcvr in reset", xcvr_en, 0);
    rst_n = 1'b1;
    tick();
    check("R1 rdy after reset", cpu_rdy, 1);
    check("R1 active after reset", slow_active, 0);
  endtask

  task automatic test_unarmed();
    int stalls = 0;
    wait_phase(1);
    slow_hit = 1'b1;
    for (int i = 0; i < 20; i++) begin
      tick();
      if (!cpu_rdy || slow_active) stalls++;
    end
    check("R2 no stall before vector fetch", stalls, 0);
    slow_hit = 1'b0;
    tick(); tick();
    vector_fetch = 1'b1;
    tick();
    vector_fetch = 1'b0;
    tick(); tick();
  endtask

  task automatic run_access(input int start_ph, input bit stretch, input string tag);
    int kexp = open_index(start_ph);
    int k_open = -1;
    int k_stall = -1;
    int early = 0;
    int act_cnt = 0;
    int rdy_ph = -1;
    int hold_ph = -1;
    int xcvr_bad = 0;
    int extra = 0;
    bit seen_end = 0;
    wait_phase(start_ph);
    slow_hit = 1'b1;
    for (int n = 1; n < 40; n++) begin
      tick();
      if (k_stall < 0 && !cpu_rdy) k_stall = n;
      if (slow_active) begin
        if (k_open < 0) k_open = n;
        act_cnt++;
        if (xcvr_en != !bank_latch) xcvr_bad++;
      end else if (xcvr_en) xcvr_bad++;
      if (k_open < 0 && k_stall > 0 && slow_hold) early++;
      if (k_open > 0 && !seen_end && !slow_active) begin
        seen_end = 1; rdy_ph = cpu_rdy ? int'(ph) : -1;
      end
      if (seen_end && hold_ph < 0 && !slow_hold) hold_ph = int'(ph);
      if (stretch && n == k_open) bus_ready = 1'b0;
      if (stretch && n == k_open + 4) bus_ready = 1'b1;
      bank_latch = (k_open > 0 && slow_active) ? ~bank_latch : 1'b0;
    end
    bank_latch = 1'b0;
    check({"R4 stall edge ", tag}, k_stall, 2);
    check({"R5 R6 open edge ", tag}, k_open, kexp);
    check({"R6 no early select ", tag}, early, 0);
    check({"R7 R8 cycle length ", tag}, act_cnt, stretch ? 10 : 2);
    check({"R7 rdy back at end ", tag}, rdy_ph, 0);
    check({"R9 hold drop phase ", tag}, hold_ph, 1);
    check({"R10 xcvr gating ", tag}, xcvr_bad, 0);
    for (int i = 0; i < 16; i++) begin
      tick();
      if (!cpu_rdy || slow_active) extra++;
    end
    check({"R3 held decode no rerun ", tag}, extra, 0);
    slow_hit = 1'b0;
    tick(); tick();
  endtask

  initial begin
    test_reset();
    test_unarmed();
    run_access(1, 1'b0, "early");
    run_access(3, 1'b0, "just before q3");
    run_access(4, 1'b0, "request meets q3");
    run_access(5, 1'b0, "after q3");
    run_access(0, 1'b1, "bus not ready");
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 5000; i++) begin
      @(posedge cpu_clk);
      if (done) break;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule